// File: doc/BRIEF.md
# Protection Fault Status and Interrupt Controller

This block sits between a charger's protection comparators and its host register interface. Each cycle it samples nine event inputs and qualifies each one against the operating state. For every event it keeps a live status bit and a sticky flag bit. From these it drives an active-low interrupt pin, a charge-enable bit and the run permission for the power-stage switch.

The host uses two control words per event, a mask word and a disable word, and they act differently. A masked event still updates its bits and still stops the converter, but it does not pull the interrupt. A disabled event is held silent: its bits stay at zero and it never interrupts. The bus undercurrent event is the one exception. When it is disabled it still reports, and it only loses the ability to stop the converter. Every fault except undercurrent also drops the charge-enable bit. That bit then stays low until the host writes it again.

The register port is a plain one-cycle read/write strobe interface with no back-pressure. A read returns its data with `rd_valid` one cycle after the strobe. No stream interface exists because no data flows through the block.

Top module: `prot_fault_ctrl`

## Requirements
- R1: After reset, chg_en=0, sw_on=0, irq_n=1, and the status, flag, mask and disable words all read 0.
- R2: The event bit order is: 0 input OV, 1 die over-temperature, 2 thermal-sensor fault, 3 bus OV, 4 battery OV, 5 bus OC, 6 battery OC, 7 bus reverse current, 8 bus UC.
  - op_state 0 (battery only) arms no event.
  - op_state 1 (input present, charging off) arms bits 0-4.
  - op_state 2 (soft-start) arms bits 0-7.
  - op_state 3 (after soft-start) arms all bits.
  - An unarmed event leaves its status and flag at 0.
- R3: A status bit equals its armed, enabled raw input as registered on the previous clock edge. It follows the input both up and down.
- R4: A flag bit sets on the clock edge where its status bit rises. A read of address 2 returns the flags and clears them. A rise on the same edge as that read survives the clear.
- R5: irq_n is low exactly while some flag bit is set with its mask bit (address 3) at 0.
- R6: A set mask bit does not change that event's status, flag or shutdown action.
- R7: Setting a disable bit (address 4) for events 0-7 holds that event's status and flag at 0. The event then raises no interrupt, causes no shutdown and leaves chg_en unchanged.
- R8: With disable bit 8 set, bus UC still sets status and flag and pulls irq_n low, but sw_on is not dropped.
- R9: sw_on = chg_en and no status bit is set whose disable bit is 0. A set status among bits 0-7 clears chg_en on the next edge. Bus UC does not clear chg_en.
- R10: chg_en (address 0, bit 0) stays 0 after the fault clears. It returns to 1 only when the host writes it, and such a write is ignored while a bit 0-7 status is set.
- R11: The register map is: address 0 control, 1 status, 2 flags, 3 mask, 4 disable. Other addresses read 0 and ignore writes. rd_data and rd_valid appear one cycle after reg_rd, and reads work in every op_state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_state | input | 2 | Operating state code (0..3) |
| evt_raw | input | 9 | Raw comparator event inputs |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 9 | Write data |
| reg_rd | input | 1 | Read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after reg_rd |
| rd_data | output | 9 | Read data |
| irq_n | output | 1 | Active-low interrupt |
| chg_en | output | 1 | Charge-enable control bit |
| sw_on | output | 1 | Power-stage switch/converter run permission |

## Verification
The main function is tested in five ways:
- A plain enabled fault, which separates the live status from the sticky flag and from clear-on-read.
- The same fault with its mask bit set, which shows that masking and shutdown are independent.
- A disabled non-UC event, which should produce nothing at all.
- Bus UC, once disabled and once enabled, which separates reporting from stopping the converter.

Each operating state is then given events of every class to expose wrong arming. A flag read is also made on the same edge as a new rise, to show whether the clear swallows the rise.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int NEV    = 9;
  localparam int ADDR_W = 3;
  localparam int UC_IDX = 8;

  typedef enum logic [1:0] {
    ST_BATT = 2'd0,
    ST_IDLE = 2'd1,
    ST_SOFT = 2'd2,
    ST_RUN  = 2'd3
  } op_state_e;

  // arming classes
  localparam logic [NEV-1:0] CLS_SUPPLY = 9'h01F; // armed with input present
  localparam logic [NEV-1:0] CLS_CHG    = 9'h0E0; // armed in soft-start and run
  localparam logic [NEV-1:0] CLS_RUN    = 9'h100; // armed after soft-start only
  localparam logic [NEV-1:0] UC_BIT     = 9'h100;
  localparam logic [NEV-1:0] FAULT_SET  = ~UC_BIT; // events that drop charge-enable

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIS  = 3'd4;
endpackage

// File: rtl/prot_arm.sv
module prot_arm
  import prot_pkg::*;
#(
  parameter int N = NEV
) (
  input  logic [1:0]   op_state,
  output logic [N-1:0] armed
);
  op_state_e st;
  assign st = op_state_e'(op_state);

  for (genvar i = 0; i < N; i++) begin : g_ev
    if (CLS_SUPPLY[i]) begin : g_sup
      assign armed[i] = (st != ST_BATT);
    end else if (CLS_CHG[i]) begin : g_chg
      assign armed[i] = (st == ST_SOFT) || (st == ST_RUN);
    end else begin : g_run
      assign armed[i] = (st == ST_RUN);
    end
  end
endmodule

// File: rtl/prot_evt_bank.sv
module prot_evt_bank #(
  parameter int N = prot_pkg::NEV
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] armed,
  input  logic [N-1:0] hold,
  input  logic         flag_clr,
  output logic [N-1:0] stat,
  output logic [N-1:0] flag
);
  logic [N-1:0] stat_d, rise;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign stat_d[i] = raw[i] & armed[i] & ~hold[i];
    assign rise[i]   = stat_d[i] & ~stat[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat[i] <= 1'b0;
        flag[i] <= 1'b0;
      end else begin
        stat[i] <= stat_d[i];
        flag[i] <= ((flag[i] & ~flag_clr) | rise[i]) & ~hold[i];
      end
    end
  end

  p_unarmed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed == '0) |=> (stat == '0));
  p_flag_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat) & ~flag) == '0));
  p_hold_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) == hold |-> (((stat | flag) & hold) == '0));
endmodule

// File: rtl/prot_regs.sv
module prot_regs
  import prot_pkg::*;
#(
  parameter int N  = NEV,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [N-1:0]  wdata,
  input  logic          rd,
  input  logic [N-1:0]  stat,
  input  logic [N-1:0]  flag,
  input  logic          fault_hit,
  output logic [N-1:0]  mask,
  output logic [N-1:0]  dis,
  output logic          chg_en,
  output logic          flag_clr,
  output logic          rd_valid,
  output logic [N-1:0]  rd_data
);
  logic [N-1:0] rd_mux;

  assign flag_clr = rd && (addr == A_FLAG);

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:  rd_mux[0] = chg_en;
      A_STAT:  rd_mux = stat;
      A_FLAG:  rd_mux = flag;
      A_MASK:  rd_mux = mask;
      A_DIS:   rd_mux = dis;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask     <= '0;
      dis      <= '0;
      chg_en   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rd_mux;
      if (wr && addr == A_MASK) mask <= wdata;
      if (wr && addr == A_DIS)  dis  <= wdata;
      if (fault_hit)                   chg_en <= 1'b0;
      else if (wr && addr == A_CTRL)   chg_en <= wdata[0];
    end
  end

  p_fault_drops_chg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> !chg_en);
  p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid);
endmodule

// File: rtl/prot_fault_ctrl.sv
module prot_fault_ctrl
  import prot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_state,
  input  logic [NEV-1:0]    evt_raw,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [NEV-1:0]    reg_wdata,
  input  logic              reg_rd,
  output logic              rd_valid,
  output logic [NEV-1:0]    rd_data,
  output logic              irq_n,
  output logic              chg_en,
  output logic              sw_on
);
  logic [NEV-1:0] armed, stat, flag, mask, dis, hold, shut;
  logic           flag_clr, fault_hit;

  prot_arm #(.N(NEV)) u_arm (
    .op_state (op_state),
    .armed    (armed)
  );

  // undercurrent keeps reporting when disabled; others go silent
  assign hold = dis & ~UC_BIT;

  prot_evt_bank #(.N(NEV)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (evt_raw),
    .armed    (armed),
    .hold     (hold),
    .flag_clr (flag_clr),
    .stat     (stat),
    .flag     (flag)
  );

  assign fault_hit = |(stat & FAULT_SET);

  prot_regs #(.N(NEV), .AW(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (reg_addr),
    .wr        (reg_wr),
    .wdata     (reg_wdata),
    .rd        (reg_rd),
    .stat      (stat),
    .flag      (flag),
    .fault_hit (fault_hit),
    .mask      (mask),
    .dis       (dis),
    .chg_en    (chg_en),
    .flag_clr  (flag_clr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  assign shut  = stat & ~dis;
  assign sw_on = chg_en & ~(|shut);
  assign irq_n = ~(|(flag & ~mask));

  p_shut_blocks_switch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|shut) |-> !sw_on);
  p_masked_no_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~mask) == '0) |-> irq_n);
  p_chg_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!chg_en) && !(($past(reg_wr)) && $past(reg_addr) == A_CTRL)) |-> !chg_en);
endmodule

// File: tb/sim_prot_fault_ctrl.sv
module sim_prot_fault_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   op_state = 2'd0;
  logic [N-1:0] evt_raw = '0;
  logic [2:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic         reg_rd = 1'b0;
  logic         rd_valid, irq_n, chg_en, sw_on;
  logic [N-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_fault_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .op_state(op_state), .evt_raw(evt_raw),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_n(irq_n), .chg_en(chg_en),
    .sw_on(sw_on)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: read results arrive one cycle after the strobe
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R11: unexpected read data %h expected none", rd_data);
      end else begin
        automatic logic [N-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, rd_data, e);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [N-1:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_addr = a; reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 irq_n", irq_n, 1); chk("R1 sw_on", sw_on, 0); chk("R1 chg_en", chg_en, 0);
    rd(3'd1, 9'h000, "R1 stat"); rd(3'd2, 9'h000, "R1 flag");
    rd(3'd3, 9'h000, "R1 mask"); rd(3'd4, 9'h000, "R1 dis");

    // plain fault, run state
    op_state = 2'd3;
    wr(3'd0, 9'h001);
    chk("R9 sw_on enabled", sw_on, 1);
    evt_raw = 9'h020; tick();
    chk("R5 irq on fault", irq_n, 0); chk("R9 sw_on off", sw_on, 0);
    tick();
    chk("R9 chg_en cleared", chg_en, 0);
    rd(3'd1, 9'h020, "R3 stat live");
    rd(3'd2, 9'h020, "R4 flag set");
    rd(3'd2, 9'h000, "R4 flag cleared by read");
    chk("R5 irq released", irq_n, 1);
    evt_raw = '0; tick(); tick();
    rd(3'd1, 9'h000, "R3 stat follows input down");
    chk("R10 chg_en stays low", chg_en, 0);
    wr(3'd0, 9'h001);
    chk("R10 chg_en rewritten", chg_en, 1);

    // masked fault
    wr(3'd3, 9'h002);
    evt_raw = 9'h002; tick();
    chk("R6 masked no irq", irq_n, 1); chk("R6 masked still shuts", sw_on, 0);
    rd(3'd2, 9'h002, "R6 masked flag");
    evt_raw = '0; tick();
    wr(3'd3, 9'h000);
    wr(3'd0, 9'h001);

    // disabled non-UC event
    wr(3'd4, 9'h001);
    evt_raw = 9'h001; tick();
    chk("R7 no irq", irq_n, 1); chk("R7 no shutdown", sw_on, 1);
    rd(3'd1, 9'h000, "R7 stat held");
    rd(3'd2, 9'h000, "R7 flag held");
    chk("R7 chg_en kept", chg_en, 1);
    evt_raw = '0; tick();
    wr(3'd4, 9'h000);

    // disabled UC
    wr(3'd4, 9'h100);
    evt_raw = 9'h100; tick();
    chk("R8 irq", irq_n, 0); chk("R8 keeps running", sw_on, 1);
    rd(3'd1, 9'h100, "R8 stat");
    rd(3'd2, 9'h100, "R8 flag");
    evt_raw = '0; tick();
    wr(3'd4, 9'h000);
    // enabled UC stops converter but keeps chg_en
    evt_raw = 9'h100; tick();
    chk("R9 UC stops", sw_on, 0); tick();
    chk("R9 UC keeps chg_en", chg_en, 1);
    rd(3'd2, 9'h100, "R4 UC flag");
    evt_raw = '0; tick();
    chk("R9 resumes", sw_on, 1);

    // arming per state
    op_state = 2'd1;
    evt_raw = 9'h120; tick();
    rd(3'd1, 9'h000, "R2 idle unarmed");
    chk("R2 idle irq", irq_n, 1);
    evt_raw = 9'h121; tick();
    rd(3'd1, 9'h001, "R2 idle supply armed");
    op_state = 2'd2; tick();
    rd(3'd1, 9'h021, "R2 soft-start");
    rd(3'd2, 9'h021, "R2 soft flags");
    chk("R9 chg_en dropped", chg_en, 0);
    evt_raw = '0;
    op_state = 2'd0; evt_raw = 9'h1FF; tick();
    rd(3'd1, 9'h000, "R2 battery only");
    rd(3'd2, 9'h000, "R11 read in battery only");
    evt_raw = '0; tick();

    // read coinciding with a new rise
    op_state = 2'd3;
    wr(3'd0, 9'h001);
    evt_raw = 9'h008;
    rd(3'd2, 9'h000, "R4 read same edge");
    rd(3'd2, 9'h008, "R4 rise survives");
    wr(3'd0, 9'h001);
    chk("R10 write ignored under fault", chg_en, 0);
    evt_raw = '0; tick();
    wr(3'd0, 9'h001);
    rd(3'd0, 9'h001, "R11 ctrl read");
    wr(3'd3, 9'h0A5);
    rd(3'd3, 9'h0A5, "R11 mask read");
    wr(3'd6, 9'h1FF);
    rd(3'd6, 9'h000, "R11 unmapped");
    tick(); tick();
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R11: %0d reads unanswered expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule